// File: doc/BRIEF.md
# Masked Sticky Interrupt Aggregator

This block gathers single-cycle event pulses from a video capture parser and records each one as a sticky pending bit in a 22-bit status register. A mask register chooses which pending bits may reach the top-level interrupt controller. The block ORs the unmasked pending bits into one registered interrupt line.

Software clears a pending bit through a separate, level-held clear register. Writing 1 to a clear bit drops the matching status bit. While that clear bit stays at 1, new events of that type are blocked. Software must write the clear bit back to 0 before the next event of that type can be recorded.

Two bit positions, 5 and 8, are reserved. They can never become pending, and they read as zero in every register. Software reaches the registers through a small port with a shared address, a write strobe, write data and combinational read data.

Top module: `vid_event_irq_agg`

## Requirements
- R1: After reset, status reads 0x000000, clear reads 0x000000, mask reads 0x3FFEDF (every active bit masked) and `irq_o` is 0.
- R2: An event pulse on an active bit sets that status bit at the next clock edge. The bit stays set on later cycles with no event until it is cleared.
- R3: The status register (address 0) is read-only. A write to address 0 leaves status, mask and clear unchanged.
- R4: Writing 1 to a clear bit (address 2) zeroes the matching status bit at the same edge that stores the write. While that clear bit reads 1, event pulses on that bit leave status 0. After the clear bit is written back to 0, events set the bit again.
- R5: When an event pulse and a clear-register write of 1 hit the same bit in the same cycle, the status bit ends at 0. Other bits pulsed in that cycle are still recorded.
- R6: `irq_o` is the registered OR of (status AND NOT mask). It changes one clock after a status or mask change. A mask bit of 1 keeps its pending bit from asserting `irq_o`.
- R7: Bits 5 and 8 never become 1 in status, even when pulsed. They read 0 in the mask and clear registers whatever value is written.
- R8: Address 3 reads 0x000000, and a write to it changes no register.
- R9: The mask (address 1) and clear (address 2) registers read back the last value written on the active bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| evt_i | input | 22 | Single-cycle event pulses, one per source bit |
| reg_addr_i | input | 2 | Register select for read and write: 0 status, 1 mask, 2 clear, 3 unused |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 22 | Write data |
| reg_rdata_o | output | 22 | Read data for the register at `reg_addr_i` |
| irq_o | output | 1 | Combined registered interrupt |

## Verification
An event pulse and a clear-register write can land on the same bit in the same cycle, and the clear must win. The bench provokes this in one cycle. It raises the write strobe to the clear address with one bit set, and at the same time pulses that bit together with a neighbouring bit. It then reads status. The targeted bit must be 0 and the neighbour must be 1. A second case pulses a bit whose clear is already held at 1, and status must stay 0.

// File: rtl/vea_pkg.sv
package vea_pkg;
    localparam int EVT_W  = 22;
    localparam int ADDR_W = 2;

    localparam logic [EVT_W-1:0] RSVD_BITS = (EVT_W'(1) << 5) | (EVT_W'(1) << 8);
    localparam logic [EVT_W-1:0] LIVE_BITS = ~RSVD_BITS;

    localparam logic [ADDR_W-1:0] SEL_STATUS = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] SEL_MASK   = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] SEL_CLEAR  = ADDR_W'(2);
endpackage

// File: rtl/vea_ctrl_regs.sv
module vea_ctrl_regs #(
    parameter int          W      = vea_pkg::EVT_W,
    parameter int          AW     = vea_pkg::ADDR_W,
    parameter logic [W-1:0] LIVE  = vea_pkg::LIVE_BITS
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    input  logic [W-1:0]  wdata_i,
    output logic [W-1:0]  mask_o,
    output logic [W-1:0]  clr_o,
    output logic [W-1:0]  clr_eff_o
);
    typedef struct packed {
        logic [W-1:0] mask;
        logic [W-1:0] clr;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  hit_mask, hit_clr;

    always_comb begin
        st_d     = st_q;
        hit_mask = wr_i && (addr_i == vea_pkg::SEL_MASK);
        hit_clr  = wr_i && (addr_i == vea_pkg::SEL_CLEAR);
        if (hit_mask) st_d.mask = wdata_i & LIVE;
        if (hit_clr)  st_d.clr  = wdata_i & LIVE;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.mask <= LIVE;
            st_q.clr  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o    = st_q.mask;
    assign clr_o     = st_q.clr;
    assign clr_eff_o = st_d.clr;

    AST_MASK_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_mask |=> (mask_o == ($past(wdata_i) & LIVE)));          // R9
    AST_CLR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !hit_clr |=> $stable(clr_o));                                // R4
    AST_MASK_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !hit_mask |=> $stable(mask_o));                              // R3
endmodule

// File: rtl/vea_status_bank.sv
module vea_status_bank #(
    parameter int           W    = vea_pkg::EVT_W,
    parameter logic [W-1:0] LIVE = vea_pkg::LIVE_BITS
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] evt_i,
    input  logic [W-1:0] clr_eff_i,
    output logic [W-1:0] status_o
);
    typedef struct packed {
        logic [W-1:0] pend;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pend = (st_q.pend | (evt_i & LIVE)) & ~clr_eff_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign status_o = st_q.pend;

    AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status_o & $past(clr_eff_i)) == '0);                        // R5
    AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (($past(status_o) & ~$past(clr_eff_i)) & ~status_o) == '0);  // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status_o & ~$past(status_o) & ~$past(evt_i)) == '0);        // R2
    AST_RSVD_NEVER_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status_o & ~LIVE) == '0);                                   // R7
endmodule

// File: rtl/vea_irq_reduce.sv
module vea_irq_reduce #(
    parameter int           W    = vea_pkg::EVT_W,
    parameter logic [W-1:0] LIVE = vea_pkg::LIVE_BITS
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] status_i,
    input  logic [W-1:0] mask_i,
    output logic         irq_o
);
    typedef struct packed {
        logic irq;
    } red_t;

    red_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = |(status_i & ~mask_i & LIVE);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign irq_o = st_q.irq;

    AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(status_i & ~mask_i) == '0) |-> !irq_o);               // R6
    AST_IRQ_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(status_i & ~mask_i) != '0) |-> irq_o);                // R6
endmodule

// File: rtl/vid_event_irq_agg.sv
module vid_event_irq_agg #(
    parameter int                   W    = vea_pkg::EVT_W,
    parameter int                   AW   = vea_pkg::ADDR_W,
    parameter logic [W-1:0]         LIVE = vea_pkg::LIVE_BITS
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [W-1:0]  evt_i,
    input  logic [AW-1:0] reg_addr_i,
    input  logic          reg_wr_i,
    input  logic [W-1:0]  reg_wdata_i,
    output logic [W-1:0]  reg_rdata_o,
    output logic          irq_o
);
    logic [W-1:0] mask_w, clr_w, clr_eff_w, status_w;

    vea_ctrl_regs #(.W(W), .AW(AW), .LIVE(LIVE)) u_ctrl (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_i      (reg_wr_i),
        .addr_i    (reg_addr_i),
        .wdata_i   (reg_wdata_i),
        .mask_o    (mask_w),
        .clr_o     (clr_w),
        .clr_eff_o (clr_eff_w)
    );

    vea_status_bank #(.W(W), .LIVE(LIVE)) u_status (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .evt_i     (evt_i),
        .clr_eff_i (clr_eff_w),
        .status_o  (status_w)
    );

    vea_irq_reduce #(.W(W), .LIVE(LIVE)) u_reduce (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .status_i (status_w),
        .mask_i   (mask_w),
        .irq_o    (irq_o)
    );

    always_comb begin
        unique case (reg_addr_i)
            vea_pkg::SEL_STATUS: reg_rdata_o = status_w;
            vea_pkg::SEL_MASK:   reg_rdata_o = mask_w;
            vea_pkg::SEL_CLEAR:  reg_rdata_o = clr_w;
            default:             reg_rdata_o = '0;
        endcase
    end

    AST_RSVD_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_rdata_o & ~LIVE) == '0);                                // R7
    AST_SPARE_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_addr_i == AW'(3)) |-> (reg_rdata_o == '0));             // R8
endmodule

// File: tb/vid_event_irq_agg_tb.sv
module vid_event_irq_agg_tb;
    localparam logic [21:0] LIVE = 22'h3FFEDF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [21:0] evt = '0;
    logic [1:0]  addr = '0;
    logic        wr = 1'b0;
    logic [21:0] wdata = '0;
    logic [21:0] rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    vid_event_irq_agg u_dut (
        .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .reg_addr_i(addr),
        .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
    );

    task automatic check(input string req, input logic [21:0] act, input logic [21:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [21:0] d);
        addr = a; wdata = d; wr = 1'b1;
        tick();
        wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [21:0] d);
        addr = a; wr = 1'b0;
        #2 d = rdata;
    endtask

    task automatic pulse(input logic [21:0] e);
        evt = e;
        tick();
        evt = '0;
    endtask

    task automatic wipe();
        reg_write(2'd2, 22'h3FFFFF);
        reg_write(2'd2, 22'h0);
        reg_write(2'd1, 22'h3FFFFF);
        tick();
    endtask

    task automatic t_reset();
        logic [21:0] v;
        reg_read(2'd0, v); check("R1 status", v, 22'h0);
        reg_read(2'd1, v); check("R1 mask", v, LIVE);
        reg_read(2'd2, v); check("R1 clear", v, 22'h0);
        check("R1 irq", {21'h0, irq}, 22'h0);
    endtask

    task automatic t_sticky();
        logic [21:0] v;
        wipe();
        pulse(22'h200001);
        reg_read(2'd0, v); check("R2 set", v, 22'h200001);
        repeat (3) tick();
        reg_read(2'd0, v); check("R2 sticky", v, 22'h200001);
        check("R6 masked irq", {21'h0, irq}, 22'h0);
    endtask

    task automatic t_readonly();
        logic [21:0] v;
        reg_write(2'd0, 22'h0);
        reg_read(2'd0, v); check("R3 status kept", v, 22'h200001);
        reg_write(2'd0, 22'h3FFFFF);
        reg_read(2'd0, v); check("R3 status kept2", v, 22'h200001);
        reg_read(2'd1, v); check("R3 mask kept", v, LIVE);
        reg_read(2'd2, v); check("R3 clear kept", v, 22'h0);
    endtask

    task automatic t_mask_irq();
        logic [21:0] v;
        wipe();
        pulse(22'h000001);
        check("R6 irq masked", {21'h0, irq}, 22'h0);
        reg_write(2'd1, LIVE & ~22'h1);
        check("R6 irq latency", {21'h0, irq}, 22'h0);
        tick();
        check("R6 irq up", {21'h0, irq}, 22'h1);
        reg_write(2'd1, LIVE);
        check("R6 irq still up", {21'h0, irq}, 22'h1);
        tick();
        check("R6 irq down", {21'h0, irq}, 22'h0);
        reg_read(2'd0, v); check("R6 status unaffected", v, 22'h1);
    endtask

    task automatic t_clear();
        logic [21:0] v;
        wipe();
        pulse(22'h000801);
        reg_write(2'd2, 22'h000001);
        reg_read(2'd0, v); check("R4 cleared", v, 22'h000800);
        pulse(22'h000001);
        reg_read(2'd0, v); check("R4 blocked", v, 22'h000800);
        reg_read(2'd2, v); check("R4 clear held", v, 22'h000001);
        reg_write(2'd2, 22'h0);
        pulse(22'h000001);
        reg_read(2'd0, v); check("R4 rearmed", v, 22'h000801);
    endtask

    task automatic t_collide();
        logic [21:0] v;
        wipe();
        pulse(22'h000004);
        addr = 2'd2; wdata = 22'h000004; wr = 1'b1; evt = 22'h000014;
        tick();
        wr = 1'b0; evt = '0;
        reg_read(2'd0, v); check("R5 clear wins", v, 22'h000010);
        reg_write(2'd2, 22'h0);
    endtask

    task automatic t_reserved();
        logic [21:0] v;
        wipe();
        pulse(22'h3FFFFF);
        reg_read(2'd0, v); check("R7 status rsvd", v, LIVE);
        reg_write(2'd1, 22'h3FFFFF);
        reg_read(2'd1, v); check("R7 mask rsvd", v, LIVE);
        reg_write(2'd1, 22'h0AAAAA);
        reg_read(2'd1, v); check("R9 mask readback", v, 22'h0AAAAA & LIVE);
        reg_write(2'd2, 22'h3FFFFF);
        reg_read(2'd2, v); check("R7 clear rsvd", v, LIVE);
        reg_write(2'd2, 22'h155555);
        reg_read(2'd2, v); check("R9 clear readback", v, 22'h155555 & LIVE);
        reg_write(2'd2, 22'h0);
    endtask

    task automatic t_spare();
        logic [21:0] v;
        wipe();
        reg_write(2'd3, 22'h3FFFFF);
        reg_read(2'd3, v); check("R8 spare read", v, 22'h0);
        reg_read(2'd1, v); check("R8 mask kept", v, LIVE);
        reg_read(2'd2, v); check("R8 clear kept", v, 22'h0);
        reg_read(2'd0, v); check("R8 status kept", v, 22'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sticky();
        t_readonly();
        t_mask_irq();
        t_clear();
        t_collide();
        t_reserved();
        t_spare();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule